// File: doc/BRIEF.md
# Chunked Buffer-Fill Command Generator

This block turns one request to fill a memory buffer with a repeated byte into a stream of 32-bit command words. The words leave on a valid/ready output. A request carries a 40-bit destination address, a byte count and the fill byte. The generator cuts the fill into chunks of at most `CHUNK_MAX` bytes, which is 2^21 − 8 by default. For each chunk it emits a six-word fill packet followed by a two-word no-op packet. The second word of the no-op packet is a relocation value taken from a constant input. Only the packet for the final chunk carries the completion-sync flag.

A request is taken only while the generator is idle. A request whose address or size is not a multiple of four, or whose size is zero, is refused. A refused request raises a one-cycle error flag and produces no output. After the last word of an accepted request has been transferred, a one-cycle done pulse follows.

The controller has three states:
- `S_IDLE` waits for a request.
- `S_FILL` emits word slots 0–5.
- `S_NOP` emits word slots 6–7.

It has four transitions:
- `S_IDLE→S_FILL` on an accepted, well-formed request.
- `S_FILL→S_NOP` when slot 5 is transferred.
- `S_NOP→S_FILL` when slot 7 is transferred and more bytes remain.
- `S_NOP→S_IDLE` when slot 7 of the final chunk is transferred.

Top module: `fill_cmd_gen`

## Requirements
- R1: A request with address bits [1:0] non-zero, size bits [1:0] non-zero, or size zero raises `error` for the one cycle after it is presented. It produces no output word and leaves the block idle, with `req_ready` high.
- R2: Each fill packet is six words in this order:
  - the header `0xC0044100` (type 3 in [31:30], count 4 in [29:16], opcode 0x41 in [15:8]);
  - the fill word;
  - the control word;
  - the chunk address bits [31:0];
  - the chunk address bits [39:32] in bits [7:0], with the other bits zero;
  - the byte count in bits [20:0], with the other bits zero.
- R3: The fill word is the fill byte repeated in all four byte lanes.
- R4: The control word has value 2 in bits [30:29] (immediate data). Bit 31 (sync) is set only in the packet of the chunk that completes the request. All other bits are zero.
- R5: Each chunk's byte count is the smaller of the remaining size and `CHUNK_MAX`. The remaining size drops by that count after each chunk, and chunks continue until it reaches zero.
- R6: The first chunk's address is the request address. Each following chunk's address is the previous address plus the previous byte count, with carry across bit 31 into the upper byte.
- R7: Every fill packet is followed by a no-op packet made of the header `0xC0001000` (count 0, opcode 0x10) and then the value of `reloc_word`.
- R8: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and `out_data` does not change.
- R9: `req_ready` is high only while no request is in progress. `done` is high for exactly the one cycle after the final word is transferred.
- R10: During and right after reset, `out_valid`, `done` and `error` are low and `req_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Fill request present |
| req_ready | output | 1 | Generator idle, request will be taken |
| req_addr | input | 40 | Destination byte address |
| req_size | input | 32 | Fill length in bytes |
| req_fill | input | 8 | Fill byte |
| reloc_word | input | 32 | Constant placed in each no-op packet |
| out_valid | output | 1 | Command word available |
| out_ready | input | 1 | Consumer takes the word |
| out_data | output | 32 | Command word |
| done | output | 1 | One-cycle pulse after the final word |
| error | output | 1 | One-cycle pulse for a refused request |

## Verification
A wrong word slot counter shows up at the first fill packet of a request. The header, an address word or a no-op word then lands in the wrong place, within eight transfers of acceptance. A wrong remaining-size or address register only shows up at a chunk boundary, as a bad byte count, a bad address or a misplaced sync bit. For this reason, a small `CHUNK_MAX` with sizes swept across several multiples of it drives each request through many boundaries within a few dozen cycles. A wrong state under back-pressure shows up as a changed word while the consumer stalls, so the consumer's ready is varied by a pseudo-random pattern.

// File: rtl/fill_cmd_pkg.sv
package fill_cmd_pkg;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_FILL = 2'd1,
        S_NOP  = 2'd2
    } fill_state_t;

    localparam logic [7:0]  OP_FILL    = 8'h41;
    localparam logic [7:0]  OP_NOP     = 8'h10;
    localparam logic [2:0]  SLOT_LAST_FILL = 3'd5;
    localparam logic [2:0]  SLOT_LAST_NOP  = 3'd7;
    localparam logic [1:0]  SRC_IMM    = 2'd2;

    function automatic logic [31:0] make_header(input logic [13:0] cnt, input logic [7:0] op);
        return {2'b11, cnt, op, 8'h00};
    endfunction

    function automatic logic [31:0] rep_byte(input logic [7:0] b);
        return {4{b}};
    endfunction

endpackage

// File: rtl/fill_chunk_calc.sv
module fill_chunk_calc #(
    parameter int SIZE_W    = 32,
    parameter int CHUNK_MAX = (1 << 21) - 8
) (
    input  logic [SIZE_W-1:0] remaining,
    output logic [SIZE_W-1:0] chunk,
    output logic              last
);
    localparam logic [SIZE_W-1:0] LIMIT = SIZE_W'(CHUNK_MAX);

    always_comb begin
        last  = (remaining <= LIMIT);
        chunk = last ? remaining : LIMIT;
    end
endmodule

// File: rtl/fill_word_mux.sv
module fill_word_mux #(
    parameter int ADDR_W = 40
) (
    input  logic [2:0]        slot,
    input  logic [31:0]       fill_word,
    input  logic              last,
    input  logic [ADDR_W-1:0] addr,
    input  logic [20:0]       count,
    input  logic [31:0]       reloc,
    output logic [31:0]       word
);
    import fill_cmd_pkg::*;

    localparam int HI_W = ADDR_W - 32;

    always_comb begin
        unique case (slot)
            3'd0: word = make_header(14'd4, OP_FILL);
            3'd1: word = fill_word;
            3'd2: word = {last, SRC_IMM, 29'd0};
            3'd3: word = addr[31:0];
            3'd4: word = {{(32-HI_W){1'b0}}, addr[ADDR_W-1:32]};
            3'd5: word = {11'd0, count};
            3'd6: word = make_header(14'd0, OP_NOP);
            3'd7: word = reloc;
            default: word = 32'd0;
        endcase
    end
endmodule

// File: rtl/fill_cmd_gen.sv
module fill_cmd_gen #(
    parameter int ADDR_W    = 40,
    parameter int SIZE_W    = 32,
    parameter int CHUNK_MAX = (1 << 21) - 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [SIZE_W-1:0] req_size,
    input  logic [7:0]        req_fill,
    input  logic [31:0]       reloc_word,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [31:0]       out_data,
    output logic              done,
    output logic              error
);
    import fill_cmd_pkg::*;

    fill_state_t       state_q, state_d;
    logic [2:0]        slot_q;
    logic [ADDR_W-1:0] addr_q;
    logic [SIZE_W-1:0] rem_q;
    logic [31:0]       fill_q;
    logic              done_q, err_q;

    logic [SIZE_W-1:0] chunk;
    logic              last;
    logic              req_fire, req_bad, xfer;

    fill_chunk_calc #(.SIZE_W(SIZE_W), .CHUNK_MAX(CHUNK_MAX)) u_chunk (
        .remaining(rem_q),
        .chunk    (chunk),
        .last     (last)
    );

    fill_word_mux #(.ADDR_W(ADDR_W)) u_mux (
        .slot     (slot_q),
        .fill_word(fill_q),
        .last     (last),
        .addr     (addr_q),
        .count    (chunk[20:0]),
        .reloc    (reloc_word),
        .word     (out_data)
    );

    assign req_fire = req_valid && (state_q == S_IDLE);
    assign req_bad  = (|req_addr[1:0]) || (|req_size[1:0]) || (req_size == '0);
    assign xfer     = out_valid && out_ready;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (req_fire && !req_bad) state_d = S_FILL;
            S_FILL: if (xfer && slot_q == SLOT_LAST_FILL) state_d = S_NOP;
            S_NOP:  if (xfer && slot_q == SLOT_LAST_NOP) state_d = last ? S_IDLE : S_FILL;
            default: state_d = S_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    // datapath and pulse registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q <= '0;
            addr_q <= '0;
            rem_q  <= '0;
            fill_q <= '0;
            done_q <= 1'b0;
            err_q  <= 1'b0;
        end else begin
            done_q <= 1'b0;
            err_q  <= req_fire && req_bad;
            if (req_fire && !req_bad) begin
                slot_q <= '0;
                addr_q <= req_addr;
                rem_q  <= req_size;
                fill_q <= rep_byte(req_fill);
            end else if (xfer) begin
                slot_q <= slot_q + 3'd1;
                if (slot_q == SLOT_LAST_NOP) begin
                    rem_q  <= rem_q - chunk;
                    addr_q <= addr_q + ADDR_W'(chunk);
                    done_q <= last;
                end
            end
        end
    end

    // outputs
    always_comb begin
        req_ready = (state_q == S_IDLE);
        out_valid = (state_q == S_FILL) || (state_q == S_NOP);
        done      = done_q;
        error     = err_q;
    end
endmodule

// File: rtl/fill_cmd_gen_chk.sv
module fill_cmd_gen_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_ready,
    input logic        out_valid,
    input logic        out_ready,
    input logic [31:0] out_data,
    input logic        done,
    input logic        error
);
    AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_data)); // R8
    AST_READY_IDLE_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_ready && out_valid)); // R9
    AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done); // R9
    AST_DONE_AFTER_XFER: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(done) |-> $past(out_valid && out_ready)); // R9
    AST_ERR_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        error |-> !out_valid && req_ready); // R1
    AST_PULSES_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && error)); // R1
endmodule

bind fill_cmd_gen fill_cmd_gen_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_ready(req_ready),
    .out_valid(out_valid),
    .out_ready(out_ready),
    .out_data (out_data),
    .done     (done),
    .error    (error)
);

// File: tb/fill_cmd_gen_test.sv
module fill_cmd_gen_test;
    localparam int TB_CHUNK = 24;
    localparam int WD_LIMIT = 150000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [39:0] req_addr = '0;
    logic [31:0] req_size = '0;
    logic [7:0]  req_fill = '0;
    logic [31:0] reloc_word = 32'h5EED_0001;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [31:0] out_data;
    logic        done;
    logic        error;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    logic [7:0] lfsr = 8'hA7;
    bit   busy_ready_mode = 1'b0;
    bit   prev_stall = 1'b0;
    logic [31:0] prev_data = '0;
    bit   finished = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    fill_cmd_gen #(.CHUNK_MAX(TB_CHUNK)) uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_size(req_size), .req_fill(req_fill),
        .reloc_word(reloc_word), .out_valid(out_valid), .out_ready(out_ready),
        .out_data(out_data), .done(done), .error(error)
    );

    task automatic check(input string req, input logic [39:0] act, input logic [39:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > WD_LIMIT) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected<%0d", cycles, WD_LIMIT);
            summary();
        end
    end

    // Wait for one transferred word; checks R8 on every stall.
    task automatic take_word(output logic [31:0] w);
        bit got = 1'b0;
        while (!got) begin
            @(negedge clk);
            if (prev_stall) begin
                check("R8 valid held", {39'd0, out_valid}, 40'd1);
                check("R8 data held", {8'd0, out_data}, {8'd0, prev_data});
            end
            lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
            out_ready = busy_ready_mode | lfsr[0];
            prev_stall = out_valid && !out_ready;
            prev_data  = out_data;
            if (out_valid && out_ready) begin
                w = out_data;
                got = 1'b1;
            end
        end
    endtask

    task automatic run_fill(input logic [39:0] a, input logic [31:0] sz, input logic [7:0] fb);
        logic [31:0] rem = sz;
        logic [39:0] ad = a;
        logic [31:0] w;
        @(negedge clk);
        check("R9 ready idle", {39'd0, req_ready}, 40'd1);
        req_valid = 1'b1; req_addr = a; req_size = sz; req_fill = fb;
        @(negedge clk);
        req_valid = 1'b0;
        check("R9 ready busy", {39'd0, req_ready}, 40'd0);
        while (rem != 0) begin
            logic [31:0] cnt = (rem < TB_CHUNK) ? rem : TB_CHUNK;
            bit fin = (rem == cnt);
            take_word(w); check("R2 fill header", {8'd0, w}, {8'd0, 32'hC004_4100});
            take_word(w); check("R3 fill word", {8'd0, w}, {8'd0, {4{fb}}});
            take_word(w); check("R4 control", {8'd0, w}, {8'd0, fin, 2'b10, 29'd0});
            take_word(w); check("R6 addr low", {8'd0, w}, {8'd0, ad[31:0]});
            take_word(w); check("R6 addr high", {8'd0, w}, {32'd0, ad[39:32]});
            take_word(w); check("R5 byte count", {8'd0, w}, {8'd0, cnt});
            take_word(w); check("R7 nop header", {8'd0, w}, {8'd0, 32'hC000_1000});
            take_word(w); check("R7 reloc", {8'd0, w}, {8'd0, reloc_word});
            rem = rem - cnt;
            ad  = ad + 40'(cnt);
        end
        @(negedge clk);
        out_ready = 1'b0; prev_stall = 1'b0;
        check("R9 done pulse", {39'd0, done}, 40'd1);
        check("R5 no extra word", {39'd0, out_valid}, 40'd0);
        @(negedge clk);
        check("R9 done cleared", {39'd0, done}, 40'd0);
    endtask

    task automatic run_bad(input logic [39:0] a, input logic [31:0] sz);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_size = sz; req_fill = 8'h3C;
        @(negedge clk);
        req_valid = 1'b0;
        check("R1 error pulse", {39'd0, error}, 40'd1);
        check("R1 no output", {39'd0, out_valid}, 40'd0);
        for (int k = 0; k < 3; k++) begin
            @(negedge clk);
            check("R1 error cleared", {39'd0, error}, 40'd0);
            check("R1 stays silent", {39'd0, out_valid}, 40'd0);
            check("R1 stays idle", {39'd0, req_ready}, 40'd1);
        end
    endtask

    initial begin
        logic [39:0] addrs [3];
        addrs[0] = 40'h00_0000_0000;
        addrs[1] = 40'h00_FFFF_FFF8;
        addrs[2] = 40'hA5_1234_5670;
        repeat (3) @(negedge clk);
        check("R10 reset valid", {39'd0, out_valid}, 40'd0);
        check("R10 reset ready", {39'd0, req_ready}, 40'd1);
        check("R10 reset done", {39'd0, done}, 40'd0);
        check("R10 reset error", {39'd0, error}, 40'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R10 after reset valid", {39'd0, out_valid}, 40'd0);
        check("R10 after reset ready", {39'd0, req_ready}, 40'd1);

        for (int m = 0; m < 2; m++) begin
            busy_ready_mode = (m == 0);
            for (int ai = 0; ai < 3; ai++) begin
                for (int s = 4; s <= 4 * TB_CHUNK; s += 4) begin
                    run_fill(addrs[ai], 32'(s), 8'(s * 7 + ai + m * 3));
                end
            end
        end

        run_bad(40'h00_0000_0001, 32'd16);
        run_bad(40'h00_0000_0002, 32'd16);
        run_bad(40'h00_0000_0003, 32'd16);
        run_bad(40'h00_0000_0010, 32'd6);
        run_bad(40'h00_0000_0010, 32'd9);
        run_bad(40'h00_0000_0010, 32'd0);
        run_fill(40'h12_0000_0100, 32'd4, 8'hFF);   // still works after refusals
        reloc_word = 32'hCAFE_F00D;
        run_fill(40'h01_0000_0000, 32'd100, 8'h00);
        summary();
    end
endmodule